// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block is a purely combinational datapath. It adds or subtracts two 32-bit operands lane by lane. Three packed formats are selected by a 2-bit code.

- **Unsigned halfword, saturating.** Two unsigned 16-bit lanes either wrap or clamp. They raise an overflow indication whether or not clamping is on.
- **Unsigned byte, halving.** Four unsigned 8-bit lanes return half the sum or difference, with optional round-up.
- **Signed halving.** Signed halving arithmetic on either two 16-bit lanes or one 32-bit word.

All lanes are evaluated side by side in the same pass. Lane 0 sits in the least significant bits.

The overflow output is a set-only pulse. The surrounding core ORs it into a sticky status bit of its own. That bit, the register file and the instruction decode all live outside this block. A single control word picks the operation:
- the add/subtract select,
- the format code,
- the saturate enable,
- the round enable.

Top module: `simd_addsub`

## Requirements
- R1: The format code `fmt` selects the lane format: 0 = unsigned halfword wrap/saturate, 1 = unsigned byte halving, 2 = signed halfword halving, 3 = signed word halving. Lane 0 holds bits [15:0] (halfwords) or [7:0] (bytes). Each lane's result depends only on the same lane of both operands.
- R2: Format 0 add: a lane whose sum exceeds 0xFFFF raises `ovf_set`. With `sat` high, that lane is clamped to 0xFFFF. A sum of exactly 0xFFFF neither flags nor clamps.
- R3: Format 0 subtract: a lane whose minuend (from `op_a`) is smaller than its subtrahend (from `op_b`) raises `ovf_set`. With `sat` high, that lane is clamped to 0x0000.
- R4: Format 0 with `sat` low: an overflowing lane returns its result modulo 2^16, and `ovf_set` is still raised.
- R5: Format 1: each byte lane forms the 9-bit sum or two's-complement difference. It adds 1 if `rnd` is high, shifts right by one and returns the low 8 bits.
- R6: Format 2: each 16-bit lane forms the 17-bit signed sum or difference. It adds 1 if `rnd` is high, shifts right arithmetically by one and returns 16 bits.
- R7: Format 3: the 33-bit signed sum or difference of the whole operands gets 1 added if `rnd` is high. It is then shifted right arithmetically by one, and the low 32 bits are returned.
- R8: The halving formats (1, 2, 3) never raise `ovf_set`, and `sat` has no effect on them. `rnd` has no effect on format 0.
- R9: `ovf_set` is the OR of the per-lane overflow conditions. One overflowing lane is enough, and it is valid in the same evaluation as `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (minuend for subtract) |
| op_b | input | 32 | Second operand (subtrahend for subtract) |
| sub | input | 1 | 0 = add, 1 = subtract |
| fmt | input | 2 | Lane format code (see R1) |
| sat | input | 1 | Saturation enable for format 0 |
| rnd | input | 1 | Round-up enable for the halving formats |
| result | output | 32 | Packed lane results |
| ovf_set | output | 1 | Set-only overflow pulse for an external sticky bit |

## Verification
The block holds no state, so any fault in a lane shows at `result` or `ovf_set` in the very evaluation that exercises it. Faults include:
- a wrong carry or borrow detect,
- a misplaced clamp,
- a lost rounding bit,
- a wrong extension bit.

The corners that expose such faults are placed on purpose:
- sums of exactly 0xFFFF against 0x10000,
- a borrow in only one lane,
- a signed difference that reaches 2^16 after rounding,
- a round-up of −1.

Each corner is checked right after its inputs settle. Randomized vectors with all four formats, both directions and every enable combination then confirm that no lane leaks into its neighbour.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        FMT_UH_SAT  = 2'd0,
        FMT_UB_HALF = 2'd1,
        FMT_SH_HALF = 2'd2,
        FMT_SW_HALF = 2'd3
    } fmt_e;

    typedef struct packed {
        logic sub;
        logic sat;
        logic rnd;
        fmt_e fmt;
    } ctrl_t;

    function automatic ctrl_t pack_ctrl(logic sub, logic sat, logic rnd, logic [1:0] fmt);
        ctrl_t c;
        c.sub = sub;
        c.sat = sat;
        c.rnd = rnd;
        c.fmt = fmt_e'(fmt);
        return c;
    endfunction

endpackage

// File: rtl/simd_usat_lane.sv
module simd_usat_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W:0] ext;

    always_comb begin
        if (sub) ext = {1'b0, a} - {1'b0, b};
        else     ext = {1'b0, a} + {1'b0, b};
        ovf = ext[W];
        if (ovf && sat) res = sub ? '0 : '1;
        else            res = ext[W-1:0];
    end

    always_comb begin
        if (!ovf && !sub)
            assert_add_no_wrap_R2: assert (res >= a);
        if (!ovf && sub)
            assert_sub_no_wrap_R3: assert (res <= a);
        if (ovf && !sat && !sub)
            assert_wrap_below_R4: assert (res < a);
    end

endmodule

// File: rtl/simd_half_lane.sv
module simd_half_lane #(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         rnd,
    output logic [W-1:0] res
);
    logic [W:0] ax;
    logic [W:0] bx;
    logic [W:0] tot;

    generate
        if (SIGNED) begin : g_sext
            assign ax = {a[W-1], a};
            assign bx = {b[W-1], b};
        end else begin : g_zext
            assign ax = {1'b0, a};
            assign bx = {1'b0, b};
        end
    endgenerate

    always_comb begin
        tot = sub ? (ax - bx) : (ax + bx);
        tot = tot + {{W{1'b0}}, rnd};
        res = W'(tot >> 1);
    end

    generate
        if (!SIGNED) begin : g_chk_u
            always_comb begin
                if (!sub)
                    assert_uavg_bounds_R5: assert (res >= ((a < b) ? a : b) && res <= ((a < b) ? b : a));
            end
        end else begin : g_chk_s
            always_comb begin
                if (!sub)
                    assert_savg_bounds_R6: assert ($signed(res) >= (($signed(a) < $signed(b)) ? $signed(a) : $signed(b))
                                               && $signed(res) <= (($signed(a) < $signed(b)) ? $signed(b) : $signed(a)));
            end
        end
    endgenerate

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_addsub_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        sub,
    input  logic [1:0]  fmt,
    input  logic        sat,
    input  logic        rnd,
    output logic [31:0] result,
    output logic        ovf_set
);
    localparam int HW = DATA_W / 2;
    localparam int BW = DATA_W / 4;
    localparam int NH = DATA_W / HW;
    localparam int NB = DATA_W / BW;

    ctrl_t ctl;
    assign ctl = pack_ctrl(sub, sat, rnd, fmt);

    logic [DATA_W-1:0] r_usat;
    logic [DATA_W-1:0] r_ubyte;
    logic [DATA_W-1:0] r_shalf;
    logic [DATA_W-1:0] r_sword;
    logic [NH-1:0]     lane_ovf;

    genvar i;
    generate
        for (i = 0; i < NH; i++) begin : g_uh
            simd_usat_lane #(.W(HW)) u_lane (
                .a   (op_a[i*HW +: HW]),
                .b   (op_b[i*HW +: HW]),
                .sub (ctl.sub),
                .sat (ctl.sat),
                .res (r_usat[i*HW +: HW]),
                .ovf (lane_ovf[i])
            );
        end
        for (i = 0; i < NB; i++) begin : g_ub
            simd_half_lane #(.W(BW), .SIGNED(1'b0)) u_lane (
                .a   (op_a[i*BW +: BW]),
                .b   (op_b[i*BW +: BW]),
                .sub (ctl.sub),
                .rnd (ctl.rnd),
                .res (r_ubyte[i*BW +: BW])
            );
        end
        for (i = 0; i < NH; i++) begin : g_sh
            simd_half_lane #(.W(HW), .SIGNED(1'b1)) u_lane (
                .a   (op_a[i*HW +: HW]),
                .b   (op_b[i*HW +: HW]),
                .sub (ctl.sub),
                .rnd (ctl.rnd),
                .res (r_shalf[i*HW +: HW])
            );
        end
    endgenerate

    simd_half_lane #(.W(DATA_W), .SIGNED(1'b1)) u_word (
        .a   (op_a),
        .b   (op_b),
        .sub (ctl.sub),
        .rnd (ctl.rnd),
        .res (r_sword)
    );

    always_comb begin
        ovf_set = 1'b0;
        unique case (ctl.fmt)
            FMT_UH_SAT: begin
                result  = r_usat;
                ovf_set = |lane_ovf;
            end
            FMT_UB_HALF: result = r_ubyte;
            FMT_SH_HALF: result = r_shalf;
            default:     result = r_sword;
        endcase
    end

    always_comb begin
        if (ovf_set)
            assert_halving_quiet_R8: assert (fmt == 2'd0);
        if (fmt == 2'd0 && lane_ovf != '0)
            assert_flag_or_R9: assert (ovf_set);
    end

endmodule

// File: tb/sim_simd_addsub.sv
module sim_simd_addsub;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 600;

    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        sub = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        sat = 1'b0;
    logic        rnd = 1'b0;
    logic [31:0] result;
    logic        ovf_set;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_addsub u0 (
        .op_a(op_a), .op_b(op_b), .sub(sub), .fmt(fmt),
        .sat(sat), .rnd(rnd), .result(result), .ovf_set(ovf_set)
    );

    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic s, input logic [1:0] f,
                                  input logic st, input logic r,
                                  output logic [31:0] res, output logic ov);
        longint x, y, d;
        res = '0;
        ov  = 1'b0;
        case (f)
            2'd0: for (int k = 0; k < 2; k++) begin
                x = longint'(a[k*16 +: 16]);
                y = longint'(b[k*16 +: 16]);
                d = s ? x - y : x + y;
                if (d > 65535 || d < 0) begin
                    ov = 1'b1;
                    if (st) d = s ? 0 : 65535;
                end
                res[k*16 +: 16] = d[15:0];
            end
            2'd1: for (int k = 0; k < 4; k++) begin
                x = longint'(a[k*8 +: 8]);
                y = longint'(b[k*8 +: 8]);
                d = (s ? x - y : x + y) + longint'(r);
                d = d >>> 1;
                res[k*8 +: 8] = d[7:0];
            end
            2'd2: for (int k = 0; k < 2; k++) begin
                x = longint'($signed(a[k*16 +: 16]));
                y = longint'($signed(b[k*16 +: 16]));
                d = (s ? x - y : x + y) + longint'(r);
                d = d >>> 1;
                res[k*16 +: 16] = d[15:0];
            end
            default: begin
                x = longint'($signed(a));
                y = longint'($signed(b));
                d = (s ? x - y : x + y) + longint'(r);
                d = d >>> 1;
                res = d[31:0];
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h sub=%0d fmt=%0d sat=%0d rnd=%0d)",
                     req, act, exp, op_a, op_b, sub, fmt, sat, rnd);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic [1:0] f, input logic st, input logic r);
        @(negedge clk);
        op_a = a; op_b = b; sub = s; fmt = f; sat = st; rnd = r;
        #1;
    endtask

    task automatic directed(input string req, input logic [31:0] a, input logic [31:0] b,
                            input logic s, input logic [1:0] f, input logic st, input logic r,
                            input logic [31:0] exp_res, input logic exp_ovf);
        apply(a, b, s, f, st, r);
        check(req, result, exp_res);
        check(req, {31'd0, ovf_set}, {31'd0, exp_ovf});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] er;
        logic        eo;
        string       tag;
        void'($urandom(32'h5EED_1234));
        #1;
        check("R1", result, 32'h0000_0000);
        check("R9", {31'd0, ovf_set}, 32'd0);

        directed("R4", 32'hFFFF_0001, 32'h0001_0002, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0003, 1'b1);
        directed("R9", 32'hFFFF_0001, 32'h0001_0002, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0003, 1'b1);
        directed("R2", 32'hFFFF_0001, 32'h0001_0002, 1'b0, 2'd0, 1'b1, 1'b0, 32'hFFFF_0003, 1'b1);
        directed("R8", 32'hFFFF_0001, 32'h0001_0002, 1'b0, 2'd0, 1'b1, 1'b1, 32'hFFFF_0003, 1'b1);
        directed("R2", 32'h1234_FFFF, 32'h0001_0000, 1'b0, 2'd0, 1'b1, 1'b0, 32'h1235_FFFF, 1'b0);
        directed("R3", 32'h0005_0003, 32'h0003_0004, 1'b1, 2'd0, 1'b1, 1'b0, 32'h0002_0000, 1'b1);
        directed("R4", 32'h0005_0003, 32'h0003_0004, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0002_FFFF, 1'b1);
        directed("R1", 32'h0003_0005, 32'h0004_0003, 1'b1, 2'd0, 1'b1, 1'b0, 32'h0000_0002, 1'b1);
        directed("R5", 32'hFF01_0080, 32'hFF00_0081, 1'b0, 2'd1, 1'b0, 1'b1, 32'hFF01_0081, 1'b0);
        directed("R5", 32'hFF01_0080, 32'hFF00_0081, 1'b0, 2'd1, 1'b0, 1'b0, 32'hFF00_0080, 1'b0);
        directed("R5", 32'h0000_0000, 32'h0000_0001, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_00FF, 1'b0);
        directed("R5", 32'h0000_0000, 32'h0000_0001, 1'b1, 2'd1, 1'b0, 1'b1, 32'h0000_0000, 1'b0);
        directed("R6", 32'h7FFF_8000, 32'h7FFF_8000, 1'b0, 2'd2, 1'b0, 1'b0, 32'h7FFF_8000, 1'b0);
        directed("R6", 32'h7FFF_0000, 32'h8000_0001, 1'b1, 2'd2, 1'b0, 1'b1, 32'h8000_0000, 1'b0);
        directed("R7", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 2'd3, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b0);
        directed("R7", 32'h0000_0000, 32'h0000_0001, 1'b1, 2'd3, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0);
        directed("R7", 32'h0000_0000, 32'h0000_0001, 1'b1, 2'd3, 1'b0, 1'b1, 32'h0000_0000, 1'b0);
        directed("R8", 32'h8000_0000, 32'h8000_0000, 1'b0, 2'd3, 1'b1, 1'b0, 32'h8000_0000, 1'b0);
        directed("R8", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'd1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);

        for (int n = 0; n < N_RANDOM; n++) begin
            logic [31:0] ra, rb;
            logic [1:0]  rf;
            ra = $urandom;
            rb = $urandom;
            rf = 2'($urandom_range(3));
            if (n % 5 == 0) ra[15:0] = 16'hFFFF - rb[15:0] + 16'(n % 2);
            apply(ra, rb, 1'($urandom), rf, 1'($urandom), 1'($urandom));
            model(op_a, op_b, sub, fmt, sat, rnd, er, eo);
            case (rf)
                2'd0:    tag = sub ? "R3" : "R2";
                2'd1:    tag = "R5";
                2'd2:    tag = "R6";
                default: tag = "R7";
            endcase
            check(tag, result, er);
            check((rf == 2'd0) ? "R9" : "R8", {31'd0, ovf_set}, {31'd0, eo});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule